// File: doc/BRIEF.md
# Target Timeout Monitor with Flag Mux

This block watches a set of interconnect targets for requests that are never answered. Every target position has a request-pending input and a response input, and each populated position runs its own cycle counter. The counter advances while a request is outstanding and returns to zero when a response arrives or the request is withdrawn. When a target stays unanswered for `LIMIT` consecutive cycles and its enable bit is set, the block latches a timeout in that target's bit of a status register.

Software programs a per-target enable (mask) register and reads the status register to find which position timed out. It clears a bit by writing 1 to it. The block drives one interrupt line, which is the OR of every enabled status bit. It also drives a fixed timeout error code. A summary flag from a second, subordinate flag mux is cascaded in through a dedicated mask and status pair. Positions that have no target attached are chosen per instance by the `POP_MASK` parameter. Those positions hold no state.

Top module: `tmon_flagmux`

## Requirements
- R1: After reset, the mask, status, secondary-mask and secondary-status registers read 0, `irq` is 0 and `err_code` is 0.
- R2: A populated, enabled target whose request stays pending without a response sets its status bit after exactly `LIMIT` rising edges, and not after `LIMIT`-1.
- R3: A response, or a dropped request, returns the target's counter to zero, so a new full `LIMIT` cycles of pending are needed before a timeout.
- R4: A target whose mask bit is 0 when its counter reaches `LIMIT` sets no status bit.
- R5: The counter saturates at `LIMIT`, so a held request produces one timeout event. Clearing the status bit rearms the counter, and a still-pending request then needs another `LIMIT` cycles.
- R6: Status bits clear only when 1 is written to them at address 1. Writing 0 leaves them unchanged.
- R7: Positions not set in `POP_MASK` are reserved. Writes to their mask bits have no effect and read back 0, and requests on them never set status (default instance: positions 0 to 29, mask reads 0x3FFF_FFFF after writing all ones).
- R8: `irq` is the OR of (status AND mask) over all positions and of (secondary status AND secondary mask). Clearing a mask bit drops its contribution but keeps the latched status bit.
- R9: `err_code` is 3 whenever `irq` is 1, and 0 otherwise.
- R10: When bit 0 of the secondary mask (address 2) is set, a high `sec_flag` latches bit 0 of the secondary status (address 3). That bit is cleared by writing 1, and `sec_flag` is ignored while the secondary mask is 0.
- R11: Register map: address 0 is the target mask, address 1 is the target status, address 2 is the secondary mask and address 3 is the secondary status. `reg_rdata` reflects `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | N_TGT | Request outstanding, per target |
| rsp | input | N_TGT | Response returned, per target |
| sec_flag | input | 1 | Summary flag from the secondary flag mux |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Timeout interrupt flag |
| err_code | output | 2 | Error code, 3 while irq is set |

## Verification
Assertions check several properties on every cycle: that counters never pass `LIMIT`, that a timeout is a single-cycle event, that reserved positions hold no state, that status bits only fall through a write of 1, that no status bit rises while its mask is off, and that the error code follows the interrupt. The exact edge on which a timeout lands, restarting after a response, rearming after a clear, the mask-off case that keeps a bit latched, and the cascaded secondary path can only be shown by the bench's timed scenarios, which read the registers back through the port.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int DATA_W = 32;
    localparam logic [1:0] TMO_CODE = 2'd3;

    typedef enum logic [1:0] {
        RA_MASK  = 2'd0,
        RA_STAT  = 2'd1,
        RA_SMASK = 2'd2,
        RA_SSTAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic [1:0] code_of(input logic active);
        return active ? TMO_CODE : 2'd0;
    endfunction
endpackage

// File: rtl/tmon_watch.sv
module tmon_watch #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pend,
    input  logic resp,
    input  logic rearm,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          active;

    assign active = pend && !resp;
    assign hit    = active && !rearm && (cnt == LIM_V - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || rearm)
            cnt <= '0;
        else if (cnt != LIM_V)
            cnt <= cnt + CW'(1);
    end

    assert_sat_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM_V);
    assert_single_event_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);
    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (!pend || resp) |=> (cnt == '0));
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int          N_TGT    = 32,
    parameter logic [31:0] POP_MASK = 32'h3FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          bus,
    input  reg_addr_e        rd_addr,
    input  logic [N_TGT-1:0] hits,
    input  logic             sec_flag,
    output logic [N_TGT-1:0] mask,
    output logic [N_TGT-1:0] status,
    output logic [N_TGT-1:0] clr_vec,
    output logic             smask,
    output logic             sstat,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [N_TGT-1:0] POP = POP_MASK[N_TGT-1:0];

    logic wr_mask, wr_stat, wr_smask, wr_sstat;
    logic sclr;

    assign wr_mask  = bus.wr && bus.addr == RA_MASK;
    assign wr_stat  = bus.wr && bus.addr == RA_STAT;
    assign wr_smask = bus.wr && bus.addr == RA_SMASK;
    assign wr_sstat = bus.wr && bus.addr == RA_SSTAT;

    assign clr_vec = wr_stat ? (bus.data[N_TGT-1:0] & POP) : '0;
    assign sclr    = wr_sstat && bus.data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            status <= '0;
            smask  <= 1'b0;
            sstat  <= 1'b0;
        end else begin
            if (wr_mask)
                mask <= bus.data[N_TGT-1:0] & POP;
            if (wr_smask)
                smask <= bus.data[0];
            status <= ((status & ~clr_vec) | (hits & mask & ~clr_vec)) & POP;
            if (sclr)
                sstat <= 1'b0;
            else if (sec_flag && smask)
                sstat <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rd_addr)
            RA_MASK:  rdata[N_TGT-1:0] = mask;
            RA_STAT:  rdata[N_TGT-1:0] = status;
            RA_SMASK: rdata[0] = smask;
            RA_SSTAT: rdata[0] = sstat;
            default:  rdata = '0;
        endcase
    end

    assert_rsvd_R7: assert property (@(posedge clk) disable iff (rst)
        ((status | mask) & ~POP) == '0);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0));
    assert_mask_gate_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(mask)) == '0));
    assert_sec_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!smask && !sstat) |=> !sstat);
endmodule

// File: rtl/tmon_flag.sv
module tmon_flag
    import tmon_pkg::*;
#(
    parameter int N_TGT = 32
) (
    input  logic [N_TGT-1:0] status,
    input  logic [N_TGT-1:0] mask,
    input  logic             sstat,
    input  logic             smask,
    output logic             irq,
    output logic [1:0]       err_code
);
    assign irq      = (|(status & mask)) || (sstat && smask);
    assign err_code = code_of(irq);
endmodule

// File: rtl/tmon_flagmux.sv
module tmon_flagmux
    import tmon_pkg::*;
#(
    parameter int          N_TGT    = 32,
    parameter int          LIMIT    = 16,
    parameter logic [31:0] POP_MASK = 32'h3FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_TGT-1:0] req_pend,
    input  logic [N_TGT-1:0] rsp,
    input  logic             sec_flag,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic [1:0]       err_code
);
    reg_wr_t          bus;
    reg_addr_e        rd_addr;
    logic [N_TGT-1:0] hits;
    logic [N_TGT-1:0] mask, status, clr_vec;
    logic             smask, sstat;

    assign rd_addr  = reg_addr_e'(reg_addr);
    assign bus.wr   = reg_wr;
    assign bus.addr = reg_addr_e'(reg_addr);
    assign bus.data = reg_wdata;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        if (POP_MASK[i]) begin : g_pop
            tmon_watch #(.LIMIT(LIMIT)) u_watch (
                .clk  (clk),
                .rst  (rst),
                .pend (req_pend[i]),
                .resp (rsp[i]),
                .rearm(clr_vec[i]),
                .hit  (hits[i])
            );
        end else begin : g_rsvd
            assign hits[i] = 1'b0;
        end
    end

    tmon_regs #(.N_TGT(N_TGT), .POP_MASK(POP_MASK)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .rd_addr (rd_addr),
        .hits    (hits),
        .sec_flag(sec_flag),
        .mask    (mask),
        .status  (status),
        .clr_vec (clr_vec),
        .smask   (smask),
        .sstat   (sstat),
        .rdata   (reg_rdata)
    );

    tmon_flag #(.N_TGT(N_TGT)) u_flag (
        .status  (status),
        .mask    (mask),
        .sstat   (sstat),
        .smask   (smask),
        .irq     (irq),
        .err_code(err_code)
    );

    assert_code_R9: assert property (@(posedge clk) disable iff (rst)
        err_code == (irq ? TMO_CODE : 2'd0));
    assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((status & mask) != '0 || (sstat && smask)));
endmodule

// File: tb/tb_tmon_flagmux.sv
module tb_tmon_flagmux;
    localparam int N = 32;
    localparam int LIM = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_pend = '0;
    logic [N-1:0]  rsp = '0;
    logic          sec_flag = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic [1:0]    err_code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmon_flagmux #(.N_TGT(N), .LIMIT(LIM), .POP_MASK(32'h3FFF_FFFF)) dut (
        .clk(clk), .rst(rst), .req_pend(req_pend), .rsp(rsp), .sec_flag(sec_flag),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .err_code(err_code)
    );

    // fields: target, enable, pending cycles, expected status bit
    typedef struct packed {
        logic [4:0] tgt;
        logic       en;
        logic [5:0] hold;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{tgt: 5'd3,  en: 1'b1, hold: 6'd15, exp: 1'b0},  // R2 one short
        '{tgt: 5'd3,  en: 1'b1, hold: 6'd16, exp: 1'b1},  // R2 exact
        '{tgt: 5'd0,  en: 1'b1, hold: 6'd20, exp: 1'b1},  // R2 low edge
        '{tgt: 5'd29, en: 1'b1, hold: 6'd16, exp: 1'b1},  // R2 top populated
        '{tgt: 5'd7,  en: 1'b0, hold: 6'd20, exp: 1'b0},  // R4 masked off
        '{tgt: 5'd30, en: 1'b1, hold: 6'd20, exp: 1'b0},  // R7 reserved
        '{tgt: 5'd31, en: 1'b1, hold: 6'd40, exp: 1'b0},  // R7 reserved
        '{tgt: 5'd12, en: 1'b1, hold: 6'd10, exp: 1'b0}   // R2 early
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R9 code idle", {30'b0, err_code}, 32'h0);

        // R7 R11 mask write of all ones
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        check("R7 mask readback", v, 32'h3FFF_FFFF);
        wr(2'd0, 32'h0);

        // table walk: R2 R4 R7
        foreach (VECS[i]) begin
            wr(2'd0, VECS[i].en ? (32'h1 << VECS[i].tgt) : 32'h0);
            req_pend[VECS[i].tgt] = 1'b1;
            wait_cyc(int'(VECS[i].hold));
            rd(2'd1, v);
            check("R2/R4/R7 table", v, VECS[i].exp ? (32'h1 << VECS[i].tgt) : 32'h0);
            req_pend = '0;
            wr(2'd1, 32'hFFFF_FFFF);
            wr(2'd0, 32'h0);
            rd(2'd1, v);
            check("R6 cleared", v, 32'h0);
        end

        // R3 response restarts the counter
        wr(2'd0, 32'h0000_0020);
        req_pend[5] = 1'b1;
        wait_cyc(10);
        rsp[5] = 1'b1;
        @(negedge clk);
        rsp[5] = 1'b0;
        wait_cyc(LIM - 1);
        rd(2'd1, v);
        check("R3 restart short", v, 32'h0);
        @(negedge clk);
        rd(2'd1, v);
        check("R3 restart full", v, 32'h20);
        check("R8 irq set", {31'b0, irq}, 32'h1);
        check("R9 code active", {30'b0, err_code}, 32'h3);

        // R5 saturation: held request, no second event, status stays
        wait_cyc(40);
        rd(2'd1, v);
        check("R5 held", v, 32'h20);
        // R6 writing zero has no effect
        wr(2'd1, 32'h0);
        rd(2'd1, v);
        check("R6 write zero", v, 32'h20);
        // R5 clear rearms with request still pending
        wr(2'd1, 32'h20);
        rd(2'd1, v);
        check("R5 after clear", v, 32'h0);
        wait_cyc(LIM - 1);
        rd(2'd1, v);
        check("R5 rearm short", v, 32'h0);
        @(negedge clk);
        rd(2'd1, v);
        check("R5 rearm full", v, 32'h20);

        // R8 mask clear hides irq, keeps status
        req_pend = '0;
        wr(2'd0, 32'h0);
        rd(2'd1, v);
        check("R8 status kept", v, 32'h20);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        check("R9 code off", {30'b0, err_code}, 32'h0);
        wr(2'd1, 32'h20);

        // R10 secondary ignored while its mask is 0
        sec_flag = 1'b1;
        @(negedge clk);
        sec_flag = 1'b0;
        rd(2'd3, v);
        check("R10 sec ignored", v, 32'h0);
        wr(2'd2, 32'h1);
        rd(2'd2, v);
        check("R11 sec mask", v, 32'h1);
        sec_flag = 1'b1;
        @(negedge clk);
        sec_flag = 1'b0;
        rd(2'd3, v);
        check("R10 sec latched", v, 32'h1);
        check("R8 sec irq", {31'b0, irq}, 32'h1);
        check("R9 sec code", {30'b0, err_code}, 32'h3);
        wr(2'd3, 32'h1);
        rd(2'd3, v);
        check("R10 sec cleared", v, 32'h0);
        check("R8 irq idle", {31'b0, irq}, 32'h0);

        // R1 reset again clears state
        wr(2'd0, 32'h1);
        req_pend[0] = 1'b1;
        wait_cyc(LIM);
        rst = 1'b1;
        req_pend = '0;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd1, v);
        check("R1 status after reset", v, 32'h0);
        rd(2'd0, v);
        check("R1 mask after reset", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule